// File: doc/BRIEF.md
# Multi-Region External Bus Controller

This block connects a processor core to an external parallel bus. It serves three request ports: data write, instruction fetch and data read. When more than one port is waiting, a fixed priority picks one, and the chosen access then runs to completion. Each access is a 16-bit word. Before the bus cycle starts, the word address is compared against up to four secondary address windows and a default configuration. The comparison yields the data width, the address/data multiplexing mode, the wait-state count and the chip-select line for the cycle.

The controller then drives the bus phases. In multiplexed mode it first runs an address-latch phase. It then runs a command phase with the read or write strobe active. A word that falls on an 8-bit region is moved as two byte cycles. One clock of `clk` is one state time.

A request is a level. It stays high until the matching done pulse appears, and it is dropped in that cycle or later. The port that has just finished is not granted again in its own done cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: When several requests are pending in an idle cycle, the grant goes first to the write port, then to the fetch port, then to the read port. An access that has started is never pre-empted.
- R2: A window matches when it is enabled and base <= address <= limit, with both bounds inclusive. When several windows match, the lowest-numbered one is used. Its active-low `cs_n[i]` stays low from the first address or command cycle through the last command cycle, and no other `cs_n` line goes low. An address that matches no window uses the default configuration, and all `cs_n` lines stay high.
- R3: Each bus cycle has a command phase of 2 + W state times, where W is the region's wait-state count. During that phase `rd_n` (fetch and read) or `wr_n` (write) is low.
- R4: In multiplexed mode, `ale` is high for exactly one state time before each command phase, and `bus_ad_o` then carries address bits 15:0. In non-multiplexed mode, `ale` never rises.
- R5: On an 8-bit region, a word is moved as two byte cycles on lanes 7:0. The lower byte goes first, at the even address (`bus_addr` bit 0 = 0), and the upper byte follows at the odd address.
- R6: On a read or fetch, `rdata` holds the assembled word in the cycle where `rd_done` or `fetch_done` pulses. A 16-bit region samples `bus_d_i[15:0]`, and an 8-bit region samples `bus_d_i[7:0]` once per byte.
- R7: During a write command phase, `bus_ad_oe` is high and `bus_ad_o` carries the write word. On an 8-bit region, the byte for the current address is placed on lanes 7:0.
- R8: `rd_n` and `wr_n` are never low together. Each done output is a single-cycle pulse, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state time per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write request level |
| wr_addr | input | AW | Write word address (bit 0 ignored) |
| wr_data | input | 16 | Write word |
| wr_done | output | 1 | Write completion pulse |
| fetch_req | input | 1 | Instruction fetch request level |
| fetch_addr | input | AW | Fetch word address |
| fetch_done | output | 1 | Fetch completion pulse |
| rd_req | input | 1 | Data read request level |
| rd_addr | input | AW | Read word address |
| rd_done | output | 1 | Read completion pulse |
| rdata | output | 16 | Word returned by a fetch or read |
| win_en | input | NW | Window enables |
| win_base | input | NW*AW | Window lower bounds, window i at bits i*AW |
| win_lim | input | NW*AW | Window upper bounds, inclusive |
| win_w8 | input | NW | Window uses the 8-bit bus when 1 |
| win_mux | input | NW | Window uses the multiplexed bus when 1 |
| win_ws | input | NW*WS_W | Window wait-state counts |
| dflt_w8 | input | 1 | Default region 8-bit bus |
| dflt_mux | input | 1 | Default region multiplexed bus |
| dflt_ws | input | WS_W | Default region wait states |
| bus_addr | output | AW | External address |
| bus_ad_o | output | 16 | Address/data lines out |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| bus_d_i | input | 16 | Data lines in |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cs_n | output | NW | Window chip selects, active low |

## Verification
Two functions can fall in the same idle cycle. The first is arbitration between colliding requests. The second is the choice of region for the winner, made from the address the winner presents. The bench raises all three requests at the same clock edge, with addresses in different regions. It also raises a write while a fetch on a split, wait-stated region is in flight. The completion order must follow the write, fetch, read priority. Each finished access must also show the strobe length, latch pulses, chip select and data of its own region, not those of the request it beat.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        XB_IDLE = 2'd0,
        XB_ALE  = 2'd1,
        XB_CMD  = 2'd2
    } xb_state_e;

    localparam int XB_DW    = 16;
    localparam int XB_PORTS = 3;   // bit 0 write, bit 1 fetch, bit 2 read
endpackage

// File: rtl/xbus_arb.sv
module xbus_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // lowest index wins
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode #(
    parameter int AW   = 24,
    parameter int NW   = 4,
    parameter int WS_W = 3
) (
    input  logic [AW-1:0]      addr,
    input  logic [NW-1:0]      win_en,
    input  logic [NW*AW-1:0]   win_base,
    input  logic [NW*AW-1:0]   win_lim,
    input  logic [NW-1:0]      win_w8,
    input  logic [NW-1:0]      win_mux,
    input  logic [NW*WS_W-1:0] win_ws,
    input  logic               dflt_w8,
    input  logic               dflt_mux,
    input  logic [WS_W-1:0]    dflt_ws,
    output logic [NW-1:0]      sel,
    output logic               w8,
    output logic               mux,
    output logic [WS_W-1:0]    ws
);
    logic [NW-1:0] hit;

    for (genvar i = 0; i < NW; i++) begin : g_win
        assign hit[i] = win_en[i]
                      && (addr >= win_base[i*AW +: AW])
                      && (addr <= win_lim[i*AW +: AW]);
    end

    always_comb begin
        sel = '0;
        w8  = dflt_w8;
        mux = dflt_mux;
        ws  = dflt_ws;
        for (int i = NW - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                w8     = win_w8[i];
                mux    = win_mux[i];
                ws     = win_ws[i*WS_W +: WS_W];
            end
        end
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW   = 24,
    parameter int NW   = 4,
    parameter int WS_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [AW-1:0]      wr_addr,
    input  logic [15:0]        wr_data,
    output logic               wr_done,
    input  logic               fetch_req,
    input  logic [AW-1:0]      fetch_addr,
    output logic               fetch_done,
    input  logic               rd_req,
    input  logic [AW-1:0]      rd_addr,
    output logic               rd_done,
    output logic [15:0]        rdata,
    input  logic [NW-1:0]      win_en,
    input  logic [NW*AW-1:0]   win_base,
    input  logic [NW*AW-1:0]   win_lim,
    input  logic [NW-1:0]      win_w8,
    input  logic [NW-1:0]      win_mux,
    input  logic [NW*WS_W-1:0] win_ws,
    input  logic               dflt_w8,
    input  logic               dflt_mux,
    input  logic [WS_W-1:0]    dflt_ws,
    output logic [AW-1:0]      bus_addr,
    output logic [15:0]        bus_ad_o,
    output logic               bus_ad_oe,
    input  logic [15:0]        bus_d_i,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n,
    output logic [NW-1:0]      cs_n
);
    localparam int CW = WS_W + 1;

    typedef struct packed {
        xb_state_e             st;
        logic [XB_PORTS-1:0]   src;
        logic [AW-1:0]         addr;
        logic [XB_DW-1:0]      wdata;
        logic [XB_DW-1:0]      rdata;
        logic                  w8;
        logic                  mux;
        logic [WS_W-1:0]       ws;
        logic [NW-1:0]         cs;
        logic                  byte_hi;
        logic [CW-1:0]         cnt;
        logic [XB_PORTS-1:0]   done;
    } xb_regs_t;

    xb_regs_t q, d;

    logic [XB_PORTS-1:0] req_v, gnt;
    logic [AW-1:0]       cand_addr;
    logic [NW-1:0]       dec_sel;
    logic                dec_w8, dec_mux;
    logic [WS_W-1:0]     dec_ws;
    logic                last_cmd;
    logic                is_wr;

    assign req_v = {rd_req, fetch_req, wr_req} & ~q.done;

    xbus_arb #(.N(XB_PORTS)) arb_i (
        .req (req_v),
        .gnt (gnt)
    );

    always_comb begin
        if (gnt[0])      cand_addr = wr_addr;
        else if (gnt[1]) cand_addr = fetch_addr;
        else             cand_addr = rd_addr;
    end

    xbus_decode #(.AW(AW), .NW(NW), .WS_W(WS_W)) dec_i (
        .addr     (cand_addr),
        .win_en   (win_en),
        .win_base (win_base),
        .win_lim  (win_lim),
        .win_w8   (win_w8),
        .win_mux  (win_mux),
        .win_ws   (win_ws),
        .dflt_w8  (dflt_w8),
        .dflt_mux (dflt_mux),
        .dflt_ws  (dflt_ws),
        .sel      (dec_sel),
        .w8       (dec_w8),
        .mux      (dec_mux),
        .ws       (dec_ws)
    );

    assign is_wr    = q.src[0];
    assign last_cmd = (q.cnt == ({1'b0, q.ws} + CW'(1)));

    always_comb begin
        d      = q;
        d.done = '0;
        unique case (q.st)
            XB_IDLE: begin
                if (|gnt) begin
                    d.src     = gnt;
                    d.addr    = {cand_addr[AW-1:1], 1'b0};
                    d.wdata   = wr_data;
                    d.w8      = dec_w8;
                    d.mux     = dec_mux;
                    d.ws      = dec_ws;
                    d.cs      = dec_sel;
                    d.byte_hi = 1'b0;
                    d.cnt     = '0;
                    d.st      = dec_mux ? XB_ALE : XB_CMD;
                end
            end
            XB_ALE: begin
                d.st  = XB_CMD;
                d.cnt = '0;
            end
            XB_CMD: begin
                if (last_cmd) begin
                    if (!is_wr) begin
                        if (!q.w8)         d.rdata       = bus_d_i;
                        else if (q.byte_hi) d.rdata[15:8] = bus_d_i[7:0];
                        else                d.rdata[7:0]  = bus_d_i[7:0];
                    end
                    d.cnt = '0;
                    if (q.w8 && !q.byte_hi) begin
                        d.byte_hi = 1'b1;
                        d.st      = q.mux ? XB_ALE : XB_CMD;
                    end else begin
                        d.st   = XB_IDLE;
                        d.cs   = '0;
                        d.done = q.src;
                    end
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.st = XB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= XB_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_addr = q.w8 ? {q.addr[AW-1:1], q.byte_hi} : q.addr;
        if (q.st == XB_ALE)
            bus_ad_o = bus_addr[15:0];
        else if (q.w8)
            bus_ad_o = {8'h00, (q.byte_hi ? q.wdata[15:8] : q.wdata[7:0])};
        else
            bus_ad_o = q.wdata;
    end

    assign bus_ad_oe  = (q.st == XB_ALE) || (q.st == XB_CMD && is_wr);
    assign ale        = (q.st == XB_ALE);
    assign rd_n       = !(q.st == XB_CMD && !is_wr);
    assign wr_n       = !(q.st == XB_CMD && is_wr);
    assign cs_n       = ~q.cs;
    assign rdata      = q.rdata;
    assign wr_done    = q.done[0];
    assign fetch_done = q.done[1];
    assign rd_done    = q.done[2];
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ale,
    input logic          rd_n,
    input logic          wr_n,
    input logic [NW-1:0] cs_n,
    input logic          wr_done,
    input logic          fetch_done,
    input logic          rd_done
);
    p_cs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)) |-> $stable(cs_n));

    p_ale_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_ale_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_done_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_done, fetch_done, rd_done}));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || fetch_done || rd_done) |=> !(wr_done || fetch_done || rd_done));

    p_rdone_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done || fetch_done) |-> $past(!rd_n));

    p_wdone_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(!wr_n));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NW(NW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .cs_n       (cs_n),
    .wr_done    (wr_done),
    .fetch_done (fetch_done),
    .rd_done    (rd_done)
);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;
    localparam int AW   = 24;
    localparam int NW   = 4;
    localparam int WS_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              wr_req = 0, fetch_req = 0, rd_req = 0;
    logic [AW-1:0]     wr_addr = '0, fetch_addr = '0, rd_addr = '0;
    logic [15:0]       wr_data = '0;
    logic              wr_done, fetch_done, rd_done;
    logic [15:0]       rdata;
    logic [NW-1:0]     win_en, win_w8, win_mux;
    logic [NW*AW-1:0]  win_base, win_lim;
    logic [NW*WS_W-1:0] win_ws;
    logic              dflt_w8 = 0, dflt_mux = 0;
    logic [WS_W-1:0]   dflt_ws = '0;
    logic [AW-1:0]     bus_addr;
    logic [15:0]       bus_ad_o, bus_d_i;
    logic              bus_ad_oe, ale, rd_n, wr_n;
    logic [NW-1:0]     cs_n;

    logic [AW-1:0]   b_base [NW];
    logic [AW-1:0]   b_lim  [NW];
    logic            b_en   [NW];
    logic            b_w8   [NW];
    logic            b_mux  [NW];
    logic [WS_W-1:0] b_ws   [NW];

    always_comb begin
        for (int i = 0; i < NW; i++) begin
            win_base[i*AW +: AW]   = b_base[i];
            win_lim[i*AW +: AW]    = b_lim[i];
            win_en[i]              = b_en[i];
            win_w8[i]              = b_w8[i];
            win_mux[i]             = b_mux[i];
            win_ws[i*WS_W +: WS_W] = b_ws[i];
        end
    end

    xbus_ctrl #(.AW(AW), .NW(NW), .WS_W(WS_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_done(fetch_done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rdata(rdata),
        .win_en(win_en), .win_base(win_base), .win_lim(win_lim),
        .win_w8(win_w8), .win_mux(win_mux), .win_ws(win_ws),
        .dflt_w8(dflt_w8), .dflt_mux(dflt_mux), .dflt_ws(dflt_ws),
        .bus_addr(bus_addr), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_d_i(bus_d_i), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
    );

    // external memory responder: byte lane 0 carries the byte at bus_addr
    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    assign bus_d_i = {mem_byte(bus_addr | 24'd1), mem_byte(bus_addr)};

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor
    bit            mon_on = 0;
    bit            exp_w8 = 0;
    int            cmd_cnt, ale_cnt, oe_bad;
    int            cs_cnt [NW];
    logic [15:0]   ale_addr [2];
    logic [7:0]    cap_lo, cap_hi;
    logic [15:0]   cap_word;

    task automatic mon_clear();
        cmd_cnt = 0; ale_cnt = 0; oe_bad = 0;
        for (int i = 0; i < NW; i++) cs_cnt[i] = 0;
        ale_addr[0] = '0; ale_addr[1] = '0;
        cap_lo = '0; cap_hi = '0; cap_word = '0;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (!rd_n || !wr_n) cmd_cnt++;
            if (ale) begin
                if (ale_cnt < 2) ale_addr[ale_cnt] = bus_ad_o;
                ale_cnt++;
            end
            for (int i = 0; i < NW; i++) if (!cs_n[i]) cs_cnt[i]++;
            if (!wr_n) begin
                if (!bus_ad_oe) oe_bad++;
                if (!exp_w8) cap_word = bus_ad_o;
                else if (bus_addr[0]) cap_hi = bus_ad_o[7:0];
                else cap_lo = bus_ad_o[7:0];
            end
        end
    end

    // expected region: lowest enabled matching window, else -1
    function automatic int exp_win(input logic [AW-1:0] a);
        for (int i = 0; i < NW; i++)
            if (b_en[i] && a >= b_base[i] && a <= b_lim[i]) return i;
        return -1;
    endfunction

    // kind: 0 write, 1 fetch, 2 read
    task automatic do_access(input int kind, input logic [AW-1:0] a, input logic [15:0] wd);
        int e, nb, ws, mx, len, guard;
        logic w8;
        logic [AW-1:0] ae;
        bit seen;
        e  = exp_win(a);
        w8 = (e >= 0) ? b_w8[e] : dflt_w8;
        mx = (e >= 0) ? int'(b_mux[e]) : int'(dflt_mux);
        ws = (e >= 0) ? int'(b_ws[e]) : int'(dflt_ws);
        nb = w8 ? 2 : 1;
        ae = {a[AW-1:1], 1'b0};
        @(negedge clk);
        exp_w8 = w8;
        mon_clear();
        mon_on = 1;
        case (kind)
            0: begin wr_addr = a; wr_data = wd; wr_req = 1; end
            1: begin fetch_addr = a; fetch_req = 1; end
            default: begin rd_addr = a; rd_req = 1; end
        endcase
        seen = 0;
        guard = 0;
        while (!seen && guard < 200) begin
            @(negedge clk);
            guard++;
            seen = (kind == 0) ? wr_done : (kind == 1) ? fetch_done : rd_done;
        end
        wr_req = 0; fetch_req = 0; rd_req = 0;
        mon_on = 0;
        chk("R8 done pulse seen", 32'(seen), 32'd1);
        chk("R3 command length", cmd_cnt, (2 + ws) * nb);
        chk("R4 ale count", ale_cnt, mx * nb);
        len = (mx + 2 + ws) * nb;
        for (int i = 0; i < NW; i++)
            chk($sformatf("R2 chip select %0d cycles", i), cs_cnt[i], (i == e) ? len : 0);
        if (mx != 0) begin
            chk("R4 latched address", ale_addr[0], ae[15:0]);
            if (w8) chk("R5 second byte address", ale_addr[1], ae[15:0] | 16'd1);
        end
        if (kind == 0) begin
            chk("R7 output enable during write", oe_bad, 0);
            if (w8) chk("R5 split write bytes", {cap_hi, cap_lo}, wd);
            else    chk("R7 write word", cap_word, wd);
        end else begin
            chk("R6 read word", rdata, {mem_byte(ae | 24'd1), mem_byte(ae)});
        end
    endtask

    // simultaneous requests: returns order of completions as port indices
    task automatic collide(input bit late_wr, output int ord [3]);
        int n, guard;
        n = 0;
        guard = 0;
        @(negedge clk);
        fetch_addr = 24'h110010; rd_addr = 24'h050020; wr_addr = 24'h200030;
        wr_data = 16'hBEEF;
        fetch_req = 1; rd_req = 1;
        if (!late_wr) wr_req = 1;
        while (n < 3 && guard < 400) begin
            @(negedge clk);
            guard++;
            if (late_wr && guard == 2) wr_req = 1;
            if (wr_done)    begin ord[n] = 0; n++; wr_req = 0; end
            if (fetch_done) begin ord[n] = 1; n++; fetch_req = 0; end
            if (rd_done)    begin ord[n] = 2; n++; rd_req = 0; end
        end
        wr_req = 0; fetch_req = 0; rd_req = 0;
        chk("R1 all three completed", n, 3);
    endtask

    function automatic logic [AW-1:0] pick_addr(input int r);
        case (r)
            0: return 24'h100000 | AW'($urandom_range(0, 16'hFFFF));
            1: return 24'h110000 | AW'($urandom_range(0, 16'hFFFF));
            2: return 24'h200000 | AW'($urandom_range(0, 16'hFFFF));
            3: return 24'h300000 | AW'($urandom_range(0, 8'hFF));
            default: return 24'h050000 | AW'($urandom_range(0, 16'hFFFF));
        endcase
    endfunction

    initial begin
        int ord [3];
        void'($urandom(32'd20240611));
        b_base[0] = 24'h100000; b_lim[0] = 24'h10FFFF;
        b_base[1] = 24'h108000; b_lim[1] = 24'h11FFFF; // overlaps window 0
        b_base[2] = 24'h200000; b_lim[2] = 24'h20FFFF;
        b_base[3] = 24'h300000; b_lim[3] = 24'h3000FF;
        for (int i = 0; i < NW; i++) begin
            b_en[i] = 1; b_w8[i] = 0; b_mux[i] = 0; b_ws[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R2 reset chip selects", cs_n, {NW{1'b1}});
        chk("R8 reset strobes", {rd_n, wr_n, ale}, 3'b110);
        chk("R8 reset done", {wr_done, fetch_done, rd_done}, 3'b000);
        rst_n = 1;
        @(negedge clk);

        // directed: non-mux 16-bit zero wait, default region
        do_access(2, 24'h050010, 16'h0);
        // directed: overlap region, window 0 must win (R2)
        b_mux[0] = 1; b_ws[0] = 3'd2; b_mux[1] = 0;
        do_access(1, 24'h109000, 16'h0);
        // directed: 8-bit multiplexed split write (R5)
        b_w8[2] = 1; b_mux[2] = 1; b_ws[2] = 3'd1;
        do_access(0, 24'h200041, 16'hA55A);
        // directed: 8-bit non-mux split read, max wait
        b_w8[3] = 1; b_mux[3] = 0; b_ws[3] = 3'd7;
        do_access(2, 24'h300080, 16'h0);
        // disabled window falls back to default
        b_en[3] = 0; dflt_w8 = 1; dflt_mux = 1; dflt_ws = 3'd3;
        do_access(0, 24'h300010, 16'h1234);
        b_en[3] = 1;

        // collisions (R1)
        dflt_w8 = 0; dflt_mux = 0; dflt_ws = '0;
        b_w8[1] = 1; b_mux[1] = 1; b_ws[1] = 3'd2;
        collide(0, ord);
        chk("R1 first is write", ord[0], 0);
        chk("R1 second is fetch", ord[1], 1);
        chk("R1 third is read", ord[2], 2);
        collide(1, ord);
        chk("R1 fetch not pre-empted", ord[0], 1);
        chk("R1 late write beats read", ord[1], 0);
        chk("R1 read last", ord[2], 2);

        // constrained random
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < NW; i++) begin
                b_w8[i]  = 1'($urandom_range(0, 1));
                b_mux[i] = 1'($urandom_range(0, 1));
                b_ws[i]  = WS_W'($urandom_range(0, 7));
            end
            b_en[3]  = 1'($urandom_range(0, 1));
            dflt_w8  = 1'($urandom_range(0, 1));
            dflt_mux = 1'($urandom_range(0, 1));
            dflt_ws  = WS_W'($urandom_range(0, 7));
            do_access($urandom_range(0, 2), pick_addr($urandom_range(0, 4)),
                      16'($urandom_range(0, 16'hFFFF)));
        end

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule